// File: doc/BRIEF.md
# Slotted Target Data-In Sequencer

This block is the target side of a byte-wide, asynchronous, interlocked data-in transfer. Bytes come from a local buffer RAM and go onto a bus that carries an active-low request (`req_n`) from the target and an active-low acknowledge (`ack_n`) from the initiator. An internal slot timer divides time into fixed slots of `SLOT_TICKS` clocks. The slots alternate between a DMA slot and a bus slot. Each DMA slot fetches one byte from the buffer and places it on `bus_data`. The following bus slot asserts the request. The acknowledge is only looked at in the final cycle of a bus slot. An initiator that acknowledges promptly therefore gets one byte per slot pair. One that acknowledges too late for that cycle costs a whole extra slot pair per byte.

The sequencer is a five-state machine:
- **ST_IDLE** waits for `start`.
- **ST_FETCH** is one DMA slot that reads the buffer and latches the byte.
- **ST_ARMED** holds a fetched byte while the previous acknowledge has not yet been released.
- **ST_REQ_ON** drives the request and holds the data until the acknowledge is accepted.
- **ST_DRAIN** waits for the final release and then pulses `done`.

Its transitions are:
- *accept*: ST_IDLE to ST_FETCH, on `start` with a non-zero count.
- *present*: ST_FETCH or ST_ARMED to ST_REQ_ON, at the end of a DMA slot with the acknowledge released.
- *hold-off*: ST_FETCH to ST_ARMED, at the end of a DMA slot with the acknowledge still asserted.
- *advance*: ST_REQ_ON to ST_FETCH, on an accepted acknowledge with bytes remaining.
- *last*: ST_REQ_ON to ST_DRAIN, on an accepted acknowledge for the final byte.
- *finish*: ST_DRAIN to ST_IDLE, which pulses `done`.

The buffer read port has one cycle of latency. `SLOT_TICKS` must be at least 4. With a 40-clock slot on a 100 MHz clock, one slot is 400 ns.

Top module: `din_slot_seq`

## Requirements
- R1: During and after reset, until a transfer starts, `req_n` is 1, `done` is 0, `buf_rd_en` is 0 and `bus_data` is 0.
- R2: Each byte is read from the buffer exactly once, with `buf_rd_en` high for one cycle in the first cycle of a DMA slot. The addresses are `start_addr`, `start_addr`+1, and so on, wrapping modulo 2^ADDR_W. No read is issued during a bus slot or while `req_n` is 0.
- R3: The buffer byte for address `start_addr`+k is on `bus_data` when `req_n` falls for byte k. `req_n` falls on the first edge of a bus slot. For the first byte this is exactly SLOT_TICKS clocks after the edge that sampled `start`.
- R4: While `req_n` is 0, `bus_data` does not change. `req_n` stays 0 until the acknowledge is accepted.
- R5: `ack_n` passes through a two-flop synchronizer and is judged only on the final edge of a bus slot. If `ack_n` was sampled low at least two edges before that edge, `req_n` rises on it. This gives SLOT_TICKS clocks of request per accepted byte, and one byte per 2*SLOT_TICKS clocks when the initiator releases promptly.
- R6: If the acknowledge is not accepted on a bus slot's final edge, `req_n` stays 0 through the next DMA slot and the next bus slot. Each miss adds 2*SLOT_TICKS clocks.
- R7: A new request is asserted only if the synchronized acknowledge is released on the final edge of the preceding DMA slot. Otherwise the fetched byte is held and the request waits a further slot pair of 2*SLOT_TICKS clocks.
- R8: Exactly `byte_count` requests are made. After the last byte is accepted, `done` is high for one cycle. It rises on the final edge of the first DMA slot whose end sees the acknowledge released: SLOT_TICKS clocks after the last `req_n` rise if released promptly, plus 2*SLOT_TICKS otherwise. `req_n` is 1 whenever `done` is 1.
- R9: `start` with `byte_count` 0 gives a one-cycle `done` in the cycle after the sampling edge, with no read and no request.
- R10: `start` while a transfer is in progress is ignored. Its count and address have no effect on the running transfer, and it does not cause a second transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled in ST_IDLE) |
| byte_count | input | CNT_W | Number of bytes to transfer |
| start_addr | input | ADDR_W | First buffer address |
| buf_rd_en | output | 1 | Buffer read strobe |
| buf_rd_addr | output | ADDR_W | Buffer read address |
| buf_rd_data | input | DATA_W | Buffer read data, valid one cycle after the strobe |
| bus_data | output | DATA_W | Data driven to the bus |
| req_n | output | 1 | Request, active low |
| ack_n | input | 1 | Acknowledge from initiator, active low, asynchronous |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The hazard is the synchronized acknowledge reaching its accepted level on the same edge that closes a bus slot. The same applies to its release on the edge that closes a DMA slot. The bench sweeps the acknowledge assertion delay and the release delay across that edge: SLOT_TICKS-3 clocks still meets it and SLOT_TICKS-2 clocks misses it. For every byte, the interval between request falls and the request-low time are predicted arithmetically as 2*SLOT_TICKS clocks plus 2*SLOT_TICKS for each miss. The `done` distance is predicted the same way. A one-clock error in synchronizer depth or in slot sampling shifts these by a whole slot pair, so the fault is easy to see.

// File: rtl/dss_pkg.sv
package dss_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_ARMED  = 3'd2,
        ST_REQ_ON = 3'd3,
        ST_DRAIN  = 3'd4
    } seq_state_e;

    typedef enum logic {
        SLOT_DMA = 1'b0,
        SLOT_BUS = 1'b1
    } slot_kind_e;

endpackage

// File: rtl/dss_slot_timer.sv
module dss_slot_timer
    import dss_pkg::*;
#(
    parameter int SLOT_TICKS = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       run,
    output logic       slot_first,
    output logic       slot_last,
    output slot_kind_e slot_kind
);
    localparam int TICK_W = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(SLOT_TICKS - 1);

    logic [TICK_W-1:0] tick_q;

    // Restart always opens a DMA slot; otherwise slots alternate on wrap.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q    <= '0;
            slot_kind <= SLOT_DMA;
        end else if (restart) begin
            tick_q    <= '0;
            slot_kind <= SLOT_DMA;
        end else if (run) begin
            if (tick_q == LAST_TICK) begin
                tick_q    <= '0;
                slot_kind <= (slot_kind == SLOT_DMA) ? SLOT_BUS : SLOT_DMA;
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    assign slot_first = (tick_q == '0);
    assign slot_last  = (tick_q == LAST_TICK);

endmodule

// File: rtl/dss_ack_sync.sv
module dss_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n_raw,
    output logic ack_seen
);
    logic [STAGES-1:0] sync_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= ack_n_raw;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[STAGES-2:0], ack_n_raw};
            end
        end
    endgenerate

    // Active-high view of the synchronized acknowledge.
    assign ack_seen = ~sync_q[STAGES-1];

endmodule

// File: rtl/dss_xfer_ctr.sv
module dss_xfer_ctr #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W-1:0]  load_cnt,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              last_byte
);
    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain_q <= '0;
        end else if (load) begin
            cur_addr <= load_addr;
            remain_q <= load_cnt;
        end else if (step) begin
            cur_addr <= cur_addr + 1'b1;
            remain_q <= remain_q - 1'b1;
        end
    end

    assign last_byte = (remain_q == CNT_W'(1));

endmodule

// File: rtl/din_slot_seq.sv
module din_slot_seq
    import dss_pkg::*;
#(
    parameter int DATA_W          = 8,
    parameter int ADDR_W          = 8,
    parameter int CNT_W           = 8,
    parameter int SLOT_TICKS      = 40,
    parameter int ACK_SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              buf_rd_en,
    output logic [ADDR_W-1:0] buf_rd_addr,
    input  logic [DATA_W-1:0] buf_rd_data,
    output logic [DATA_W-1:0] bus_data,
    output logic              req_n,
    input  logic              ack_n,
    output logic              done
);
    seq_state_e  state_q, state_d;
    slot_kind_e  slot_kind;
    logic        slot_first, slot_last;
    logic        ack_seen;
    logic        dma_end, bus_end, in_bus_slot;
    logic        accept, empty_start, step, last_byte;
    logic        rd_pending_q, done_q;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] cur_addr;

    assign in_bus_slot = (slot_kind == SLOT_BUS);
    assign dma_end     = slot_last && !in_bus_slot;
    assign bus_end     = slot_last && in_bus_slot;
    assign accept      = (state_q == ST_IDLE) && start && (byte_count != '0);
    assign empty_start = (state_q == ST_IDLE) && start && (byte_count == '0);
    assign step        = (state_q == ST_REQ_ON) && bus_end && ack_seen;

    dss_slot_timer #(.SLOT_TICKS(SLOT_TICKS)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (accept),
        .run        (state_q != ST_IDLE),
        .slot_first (slot_first),
        .slot_last  (slot_last),
        .slot_kind  (slot_kind)
    );

    dss_ack_sync #(.STAGES(ACK_SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_n_raw (ack_n),
        .ack_seen  (ack_seen)
    );

    dss_xfer_ctr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) ctr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .step      (step),
        .load_addr (start_addr),
        .load_cnt  (byte_count),
        .cur_addr  (cur_addr),
        .last_byte (last_byte)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (dma_end) state_d = ack_seen ? ST_ARMED : ST_REQ_ON;
            end
            ST_ARMED: begin
                if (dma_end && !ack_seen) state_d = ST_REQ_ON;
            end
            ST_REQ_ON: begin
                if (step) state_d = last_byte ? ST_DRAIN : ST_FETCH;
            end
            ST_DRAIN: begin
                if (dma_end && !ack_seen) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state and slot position
    always_comb begin
        buf_rd_en   = (state_q == ST_FETCH) && slot_first && !in_bus_slot;
        buf_rd_addr = cur_addr;
        req_n       = (state_q != ST_REQ_ON);
        bus_data    = data_q;
        done        = done_q;
    end

    // Data capture one cycle after the read strobe; done pulse register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_pending_q <= 1'b0;
            data_q       <= '0;
            done_q       <= 1'b0;
        end else begin
            rd_pending_q <= buf_rd_en;
            if (rd_pending_q) data_q <= buf_rd_data;
            done_q <= empty_start ||
                      ((state_q == ST_DRAIN) && dma_end && !ack_seen);
        end
    end

endmodule

// File: rtl/dss_checker.sv
module dss_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_n,
    input logic              done,
    input logic              buf_rd_en,
    input logic [DATA_W-1:0] bus_data,
    input logic              in_bus_slot,
    input logic              slot_last,
    input logic              ack_seen
);
    assert_read_in_dma_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |-> (!in_bus_slot && req_n));

    assert_data_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n && !$past(req_n)) |-> $stable(bus_data));

    assert_release_on_bus_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_n) |-> $past(in_bus_slot && slot_last && ack_seen));

    assert_request_after_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_n) |-> $past(!in_bus_slot && slot_last && !ack_seen));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_req_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_n);

endmodule

bind din_slot_seq dss_checker #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_n       (req_n),
    .done        (done),
    .buf_rd_en   (buf_rd_en),
    .bus_data    (bus_data),
    .in_bus_slot (in_bus_slot),
    .slot_last   (slot_last),
    .ack_seen    (ack_seen)
);

// File: tb/din_slot_seq_tb_top.sv
module din_slot_seq_tb_top;
    localparam int T = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] byte_count = '0;
    logic [7:0] start_addr = '0;
    logic       ack_n = 1'b1;
    logic [7:0] buf_rd_data = '0;
    logic       buf_rd_en, req_n, done;
    logic [7:0] buf_rd_addr, bus_data;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int rd_cnt = 0;
    logic [7:0] rd_log [256];

    din_slot_seq #(.SLOT_TICKS(T)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
        .start_addr(start_addr), .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr),
        .buf_rd_data(buf_rd_data), .bus_data(bus_data), .req_n(req_n),
        .ack_n(ack_n), .done(done)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] pat(logic [7:0] a);
        return 8'(a * 8'd37 + 8'd11);
    endfunction

    always @(posedge clk) if (buf_rd_en) buf_rd_data <= pat(buf_rd_addr);

    always @(negedge clk) begin
        if (rst_n && buf_rd_en) begin
            rd_log[rd_cnt % 256] = buf_rd_addr;
            rd_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic run_xfer(input int cnt, input logic [7:0] a0, input int n_ack,
                            input int m_rel, input bit poke);
        int base, t_start, f, f_prev, r, r_last, exp_gap;
        bit slow_a, slow_r, saw_req;
        slow_a = (n_ack > T - 3);
        slow_r = (m_rel > T - 3);
        base = rd_cnt;
        f_prev = 0;
        r_last = 0;
        @(negedge clk);
        start = 1'b1; byte_count = 8'(cnt); start_addr = a0;
        t_start = cyc + 1;
        @(negedge clk);
        start = 1'b0; byte_count = 8'd0; start_addr = 8'h00;
        for (int k = 0; k < cnt; k++) begin
            while (req_n) @(negedge clk);
            f = cyc;
            if (k == 0)
                chk(f - t_start == T, "R3 first request delay", f - t_start, T);
            else begin
                exp_gap = 2 * T * (1 + int'(slow_a) + int'(slow_r));
                chk(f - f_prev == exp_gap, "R7 request spacing", f - f_prev, exp_gap);
            end
            chk(bus_data == pat(8'(a0 + k)), "R3 bus data", bus_data, pat(8'(a0 + k)));
            f_prev = f;
            if (poke && k == 0) begin
                start = 1'b1; byte_count = 8'd7; start_addr = 8'h40;
                @(negedge clk);
                start = 1'b0; byte_count = 8'd0; start_addr = 8'h00;
                repeat (n_ack - 1) @(negedge clk);
            end else begin
                repeat (n_ack) @(negedge clk);
            end
            ack_n = 1'b0;
            while (!req_n) @(negedge clk);
            r = cyc;
            chk(r - f == T * (1 + 2 * int'(slow_a)), "R6 request low time", r - f,
                T * (1 + 2 * int'(slow_a)));
            chk(bus_data == pat(8'(a0 + k)), "R4 data held", bus_data, pat(8'(a0 + k)));
            r_last = r;
            repeat (m_rel) @(negedge clk);
            ack_n = 1'b1;
        end
        while (!done) @(negedge clk);
        chk(cyc - r_last == T * (1 + 2 * int'(slow_r)), "R8 done timing", cyc - r_last,
            T * (1 + 2 * int'(slow_r)));
        @(negedge clk);
        chk(!done, "R8 done width", int'(done), 0);
        saw_req = 1'b0;
        repeat (4 * T) begin
            @(negedge clk);
            if (!req_n) saw_req = 1'b1;
        end
        chk(!saw_req, "R10 no extra request", int'(saw_req), 0);
        chk(rd_cnt - base == cnt, "R8 byte count", rd_cnt - base, cnt);
        for (int k = 0; k < cnt; k++)
            chk(rd_log[(base + k) % 256] == 8'(a0 + k), "R2 read address",
                rd_log[(base + k) % 256], 8'(a0 + k));
    endtask

    initial begin
        int base;
        bit saw_req;
        repeat (3) @(negedge clk);
        chk(req_n && !done && !buf_rd_en && bus_data == 8'h00, "R1 reset state",
            {req_n, done, buf_rd_en}, 3'b100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(req_n && !done && !buf_rd_en && bus_data == 8'h00, "R1 idle after reset",
            {req_n, done, buf_rd_en}, 3'b100);

        // R9: empty transfer
        base = rd_cnt;
        start = 1'b1; byte_count = 8'd0; start_addr = 8'h10;
        @(negedge clk);
        start = 1'b0;
        chk(done, "R9 done after empty start", int'(done), 1);
        saw_req = 1'b0;
        repeat (3 * T) begin
            @(negedge clk);
            if (!req_n || done) saw_req = 1'b1;
        end
        chk(!saw_req && rd_cnt == base, "R9 no request or read", rd_cnt - base, 0);

        // Sweep across the slot-edge boundary: delays up to T-3 meet it (R5)
        for (int cnt = 1; cnt <= 3; cnt++) begin
            run_xfer(cnt, 8'hFE, 1, 1, 1'b0);       // R5 prompt
            run_xfer(cnt, 8'hFE, T - 3, T - 3, 1'b0); // R5 boundary met
            run_xfer(cnt, 8'h20, T - 2, 1, 1'b0);   // R6 just missed
            run_xfer(cnt, 8'h7F, 2, T - 2, 1'b0);   // R7 late release
            run_xfer(cnt, 8'hFF, T - 1, T - 1, 1'b0);
        end

        // R10: start while busy
        run_xfer(2, 8'h30, 3, 1, 1'b1);

        summary();
        $finish;
    end

endmodule